// File: doc/BRIEF.md
# SMBus Register Read Slave

This block is a two-wire bus slave that lets a host read one byte at a time from an 8-bit register file. A read is a combined transfer. The host first writes a register pointer. It then issues a repeated START and reads back the byte that the register file holds at that pointer. The slave answers at a 7-bit address built from a fixed base plus a 4-bit strap value, so up to sixteen copies can share one bus.

The block runs from a system clock that is much faster than SCL and oversamples both bus lines. It never drives SDA high. It only asserts a pull-low enable, which the pad logic outside turns into an open-drain output. The pointer goes out on a port to the register file, and the selected byte comes back combinationally.

Top module: `smb_regrd_slave`

## Requirements
- R1: After reset the SDA pull-low enable is inactive and the register pointer output is 0.
- R2: The slave's 7-bit address is 0x58 plus the strap value, so the address byte with R/W=0 is 0xB0 + 2*strap (strap 0 gives 0xB0, strap 3 gives 0xB6). A matching address byte is acknowledged by pulling SDA low during the ninth SCL clock.
- R3: An address byte that does not match is not acknowledged. SDA is not pulled for the rest of that transfer, and the pointer is unchanged until the next START.
- R4: In a write transfer, the byte after the address is latched as the register pointer and acknowledged. The new pointer appears on the pointer output in the same cycle that the acknowledge pull begins.
- R5: After a repeated START and a matching address byte with R/W=1 (0xB1 + 2*strap), the slave acknowledges. It then sends the 8 bits of the register at the pointer, most significant bit first; a 0 bit is sent by pulling SDA.
- R6: When the host answers the data byte with NACK (SDA high) and then STOP, the slave returns to idle with SDA released.
- R7: When the host answers the data byte with ACK (SDA low), the slave sends the same register byte once more. After that it leaves SDA released until the next START or STOP, whatever the host answers.
- R8: The slave asserts its SDA pull only while SCL is low. It samples SDA on SCL rising edges.
- R9: A START or STOP seen in any state aborts the transfer in progress. A START restarts address reception; a pointer byte cut short by a START leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 4 | Address strap value added to the base address |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| reg_addr_o | output | 8 | Register pointer to the register file |
| reg_data_i | input | 8 | Register contents at reg_addr_o |

## Verification
Each bus line passes through two sampling registers before a START, STOP or SCL edge is recognised. The pull-low enable and the pointer output therefore change at the second clock edge after the line change, and the pull-low enable is released on the same schedule. The bench holds every SCL quarter-phase for four clocks and samples SDA and the pointer in the middle of the SCL-high phase, at least six clocks after the last SCL fall, so every result is settled by then. A STOP is checked as a released SDA after the STOP sequence has completed and the idle phase has held for a further quarter.

// File: rtl/smb_rd_pkg.sv
// Shared types for the register read slave.
// Assumes a byte-wide bus protocol and one-hot-free encoded states.
package smb_rd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // receiving address byte
        ST_AACK,   // acknowledging address
        ST_PTR,    // receiving pointer byte
        ST_PACK,   // acknowledging pointer
        ST_TX,     // sending data byte
        ST_MACK,   // sampling host ack after data
        ST_HOLD    // released, waiting for START or STOP
    } smb_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

endpackage

// File: rtl/smb_line_events.sv
// Samples SCL and SDA into the clock domain and flags START, STOP and
// SCL rising/falling edges. Assumes the bus is idle high at reset and
// each SCL phase spans at least three system clocks.
module smb_line_events
    import smb_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o,
    output logic     sda_s_o
);

    logic scl_q, sda_q, scl_d, sda_d;

    // Two-stage sampling of both lines, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    // Decode bus conditions from the current and previous samples.
    always_comb begin
        ev_o.start = scl_q & scl_d & sda_d & ~sda_q;
        ev_o.stop  = scl_q & scl_d & ~sda_d & sda_q;
        ev_o.rise  = scl_q & ~scl_d;
        ev_o.fall  = ~scl_q & scl_d;
    end

    assign sda_s_o = sda_q;

endmodule

// File: rtl/smb_addr_match.sv
// Compares a received 7-bit address with the base address plus the
// strap value. Purely combinational; the sum is taken modulo 2^7.
module smb_addr_match #(
    parameter int          STRAP_W   = 4,
    parameter logic [6:0]  BASE_ADDR = 7'h58
) (
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [6:0]         addr_i,
    output logic               hit_o
);

    logic [6:0] own_addr;

    // Form the own address and compare.
    always_comb begin
        own_addr = BASE_ADDR + 7'(strap_i);
        hit_o    = (addr_i == own_addr);
    end

endmodule

// File: rtl/smb_byte_ctrl.sv
// Transfer sequencer: receives the address and pointer bytes, sends the
// data byte, and drives the SDA pull-low enable. Assumes line events
// from smb_line_events; SDA output changes are made only on SCL falls.
module smb_byte_ctrl
    import smb_rd_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev_i,
    input  logic              sda_s_i,
    input  logic              addr_hit_i,
    input  logic [BYTE_W-1:0] reg_data_i,
    output logic [6:0]        rx_addr_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              pull_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    smb_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_dir;
    logic              host_ack;
    logic              resent;

    assign rx_addr_o = rx_sh[BYTE_W-1:1];

    // Main sequencer; START and STOP take priority over every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr_o    <= '0;
            pull_o   <= 1'b0;
            rd_dir   <= 1'b0;
            host_ack <= 1'b0;
            resent   <= 1'b0;
        end else if (ev_i.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            pull_o  <= 1'b0;
            resent  <= 1'b0;
        end else if (ev_i.stop) begin
            state  <= ST_IDLE;
            pull_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR: begin
                    if (ev_i.rise && bit_cnt != CNT_FULL) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev_i.fall && bit_cnt == CNT_FULL) begin
                        if (state == ST_PTR) begin
                            ptr_o  <= PTR_W'(rx_sh);
                            pull_o <= 1'b1;
                            state  <= ST_PACK;
                        end else if (addr_hit_i) begin
                            rd_dir <= rx_sh[0];
                            pull_o <= 1'b1;
                            state  <= ST_AACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev_i.fall) begin
                        bit_cnt <= '0;
                        if (rd_dir) begin
                            tx_sh  <= reg_data_i;
                            pull_o <= ~reg_data_i[BYTE_W-1];
                            state  <= ST_TX;
                        end else begin
                            pull_o <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                end
                ST_PACK: begin
                    if (ev_i.fall) begin
                        pull_o <= 1'b0;
                        state  <= ST_HOLD;
                    end
                end
                ST_TX: begin
                    if (ev_i.rise && bit_cnt != CNT_FULL) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev_i.fall) begin
                        if (bit_cnt == CNT_FULL) begin
                            pull_o <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            pull_o <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_i.rise) begin
                        host_ack <= ~sda_s_i;
                    end else if (ev_i.fall) begin
                        if (host_ack && !resent) begin
                            tx_sh   <= reg_data_i;
                            pull_o  <= ~reg_data_i[BYTE_W-1];
                            bit_cnt <= '0;
                            resent  <= 1'b1;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: begin
                    pull_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/smb_regrd_slave.sv
// Top of the register read slave. Address = BASE_ADDR + strap; a write
// transfer sets the pointer, a read transfer returns the byte at it.
// Assumes an external open-drain pad and a combinational register file.
module smb_regrd_slave #(
    parameter int         STRAP_W   = 4,
    parameter int         PTR_W     = 8,
    parameter logic [6:0] BASE_ADDR = 7'h58
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic [PTR_W-1:0]   reg_addr_o,
    input  logic [7:0]         reg_data_i
);

    import smb_rd_pkg::*;

    line_ev_t   ev;
    logic       sda_s;
    logic [6:0] rx_addr;
    logic       hit;

    smb_line_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev_o    (ev),
        .sda_s_o (sda_s)
    );

    smb_addr_match #(
        .STRAP_W   (STRAP_W),
        .BASE_ADDR (BASE_ADDR)
    ) i_match (
        .strap_i (strap_i),
        .addr_i  (rx_addr),
        .hit_o   (hit)
    );

    smb_byte_ctrl #(
        .PTR_W (PTR_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .sda_s_i    (sda_s),
        .addr_hit_i (hit),
        .reg_data_i (reg_data_i),
        .rx_addr_o  (rx_addr),
        .ptr_o      (reg_addr_o),
        .pull_o     (sda_pull_o)
    );

endmodule

// File: rtl/smb_rd_chk.sv
// Assertion checker for smb_regrd_slave, attached by bind below.
module smb_rd_chk #(
    parameter int STRAP_W = 4,
    parameter int PTR_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_i,
    input logic [STRAP_W-1:0] strap_i,
    input logic               sda_pull_o,
    input logic [PTR_W-1:0]   reg_addr_o,
    input logic [7:0]         reg_data_i
);

    // R1: first cycle after reset shows a released bus and pointer 0.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sda_pull_o && reg_addr_o == '0));

    // R4: the pointer only moves when the acknowledge pull begins.
    a_r4_ptr_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr_o) |-> $rose(sda_pull_o));

    // R8: the pull is asserted only after SCL has been seen low.
    a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> (!$past(scl_i) && !$past(scl_i, 2)));

    // R9: a STOP on the lines leaves SDA released two cycles later.
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> ##1 !sda_pull_o);

    // R2: pull never asserted while strap changes under an active transfer.
    a_r2_strap_static: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> $stable(strap_i));

endmodule

bind smb_regrd_slave smb_rd_chk #(
    .STRAP_W (STRAP_W),
    .PTR_W   (PTR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .strap_i    (strap_i),
    .sda_pull_o (sda_pull_o),
    .reg_addr_o (reg_addr_o),
    .reg_data_i (reg_data_i)
);

// File: tb/test_smb_regrd_slave.sv
// Bench: a host model drives the bus, a table of transfers is walked,
// then directed tests cover reset, abort and repeat-on-ACK.
module test_smb_regrd_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;       // clocks per SCL quarter phase
    localparam int WATCHDOG   = 150000;

    // {strap[3:0], 0+addr7, ptr[7:0], 2'b0, expect_ack, host_ack_on_data}
    localparam logic [23:0] VEC [0:5] = '{
        24'h058002,
        24'h35B7F2,
        24'hF67FF2,
        24'h158000,
        24'h55DA53,
        24'h25A3C2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_host = 1'b1;
    logic [3:0] strap = 4'd0;
    logic       sda_pull;
    logic [7:0] reg_addr;
    logic [7:0] reg_data;
    logic       sda_bus;

    int checks = 0;
    int fails  = 0;
    int high_pulls = 0;
    logic [7:0] model_ptr = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] reg_of(input logic [7:0] p);
        return (p * 8'd29) ^ 8'hC3;
    endfunction

    assign reg_data = reg_of(reg_addr);
    assign sda_bus  = sda_host & ~sda_pull;

    smb_regrd_slave i_smb_regrd_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .reg_addr_o (reg_addr),
        .reg_data_i (reg_data)
    );

    // R8 monitor: the pull must not start while SCL is steadily high.
    logic scl_prev = 1'b1, pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && sda_pull && !pull_prev) high_pulls++;
        scl_prev  <= scl;
        pull_prev <= sda_pull;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        sda_host = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        sda_host = 1'b1; wait_q(); wait_q();
    endtask

    // One clock pulse; returns the bus level sampled mid-high.
    task automatic bit_clk(input logic b, output logic seen);
        sda_host = b; wait_q();
        scl = 1'b1; wait_q();
        seen = sda_bus; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
        sda_host = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        acked = ~sda_bus;
        checks = checks; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            b[i] = s;
        end
        bit_clk(~host_ack, s);
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        logic [6:0] a7;
        repeat (4) @(negedge clk);
        check("R1 pull after reset", 32'(sda_pull), 32'd0);
        check("R1 pointer after reset", 32'(reg_addr), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pull idle", 32'(sda_pull), 32'd0);

        // Table-driven transfers.
        for (int v = 0; v < 6; v++) begin
            strap = VEC[v][23:20];
            a7    = VEC[v][18:12];
            wait_q();
            bus_start();
            send_byte({a7, 1'b0}, ack);
            check("R2/R3 address ack", 32'(ack), 32'(VEC[v][1]));
            if (VEC[v][1]) begin
                send_byte(VEC[v][11:4], ack);
                check("R4 pointer ack", 32'(ack), 32'd1);
                model_ptr = VEC[v][11:4];
                check("R4 pointer output", 32'(reg_addr), 32'(model_ptr));
                bus_start();
                send_byte({a7, 1'b1}, ack);
                check("R5 read address ack", 32'(ack), 32'd1);
                get_byte(VEC[v][0], d);
                check("R5 data byte", 32'(d), 32'(reg_of(model_ptr)));
                if (VEC[v][0]) begin
                    get_byte(1'b1, d);
                    check("R7 repeated byte", 32'(d), 32'(reg_of(model_ptr)));
                    get_byte(1'b0, d);
                    check("R7 released after repeat", 32'(d), 32'hFF);
                end
            end else begin
                send_byte(8'h00, ack);
                check("R3 no ack after mismatch", 32'(ack), 32'd0);
            end
            bus_stop();
            check("R6 released after stop", 32'(sda_pull), 32'd0);
            check("R3 pointer kept", 32'(reg_addr), 32'(model_ptr));
        end

        // R9: START in the middle of a pointer byte aborts it.
        strap = 4'd2;
        wait_q();
        bus_start();
        send_byte(8'hB4, ack);
        check("R9 address ack", 32'(ack), 32'd1);
        for (int i = 0; i < 4; i++) bit_clk(1'b0, ack);
        bus_start();
        check("R9 pointer unchanged", 32'(reg_addr), 32'(model_ptr));
        send_byte(8'hB5, ack);
        check("R9 restart read ack", 32'(ack), 32'd1);
        get_byte(1'b0, d);
        check("R9 data at old pointer", 32'(d), 32'(reg_of(model_ptr)));
        bus_stop();
        check("R6 idle after abort test", 32'(sda_pull), 32'd0);

        // R2: strap 0 uses the base address byte 0xB0.
        strap = 4'd0;
        wait_q();
        bus_start();
        send_byte(8'hB0, ack);
        check("R2 base address", 32'(ack), 32'd1);
        send_byte(8'h11, ack);
        model_ptr = 8'h11;
        check("R4 pointer 0x11", 32'(reg_addr), 32'h11);
        bus_stop();

        check("R8 no pull while SCL high", 32'(high_pulls), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule